// File: doc/BRIEF.md
# Hypervisor Environment Configuration and Fence Widening

This block keeps the one implemented bit of a hypervisor environment-configuration control register. That bit is a flag that makes an I/O fence also order memory. Software reads and writes the register through a simple CSR port with address, write strobe, read strobe, write data and read data. The register width is set by a parameter to 32 or 64. At 32 bits a second address maps a high-half register, which stands for bits 63:32 of the 64-bit layout. All bits of the high half are reserved.

The second interface is combinational. It takes the eight ordering bits of a decoded FENCE and the current virtualization-mode flag, and returns the effective ordering sets. When the stored flag is set and the virtualization mode is active, each device-input request also orders memory reads, and each device-output request also orders memory writes. This applies to both the predecessor set and the successor set. In every other case the effective sets are the instruction's own sets, unchanged.

The FENCE bit order on both `fence_in` and `fence_out` is [7:0] = PI, PO, PR, PW, SI, SO, SR, SW. PI and PO are predecessor device input and output. PR and PW are predecessor memory read and write. SI, SO, SR and SW are the same four in the successor set.

Top module: `hyp_envcfg_fence`

## Requirements
- R1: After reset the flag is 0. A read of the configuration address (default 12'h60A) returns all zeros, and `fence_out` equals `fence_in` even when `virt_mode` is 1.
- R2: A write to the configuration address stores `csr_wdata[0]` as the flag. A later read returns the flag in bit 0.
- R3: Bits XLEN-1:1 of the configuration register are reserved. They always read as 0, and the values written to them have no effect.
- R4: When the flag is 0 or `virt_mode` is 0, `fence_out` equals `fence_in` for every input pattern.
- R5: When the flag is 1 and `virt_mode` is 1, predecessor device input (bit 7) also sets predecessor memory read (bit 5). Predecessor device output (bit 6) also sets predecessor memory write (bit 4).
- R6: When the flag is 1 and `virt_mode` is 1, successor device input (bit 3) also sets successor memory read (bit 1). Successor device output (bit 2) also sets successor memory write (bit 0).
- R7: Widening only adds bits. Every bit set in `fence_in` is also set in `fence_out`, and bits 7, 6, 3 and 2 pass through unchanged.
- R8: With XLEN=32, the high-half address (default 12'h61A) reads as 0, ignores writes, and never raises `csr_unmapped`.
- R9: With XLEN=64, a read or write to the high-half address raises `csr_unmapped` in the cycle of the access. Read data is 0 and the flag is left unchanged.
- R10: A CSR write takes effect at the next rising clock edge. A fence presented in the same cycle as the write sees the old flag.
- R11: `csr_unmapped` stays low when there is no access and for accesses to the configuration address. Other addresses are not decoded: they read 0 and do not raise `csr_unmapped`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| csr_addr | input | AW | CSR address |
| csr_we | input | 1 | Write strobe |
| csr_re | input | 1 | Read strobe |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data (combinational, 0 when nothing is read) |
| csr_unmapped | output | 1 | Access to the high-half address when XLEN=64 |
| virt_mode | input | 1 | Current virtualization mode |
| fence_in | input | 8 | FENCE ordering bits {PI,PO,PR,PW,SI,SO,SR,SW} |
| fence_out | output | 8 | Effective ordering bits, same order |

## Verification
The bench presents every one of the 256 fence patterns under each combination of flag and mode:
- A network that swapped the memory-read and memory-write targets would fail the single-bit cases.
- A network that masked rather than ORed would lose bits that were already requested.

A fence applied in the same cycle as a write that sets the flag must still pass through unwidened; a flag read combinationally from the write data would widen it at once. The high-half address is exercised at both widths. At 32 bits it must stay silent and read 0. At 64 bits it must flag the access and must not disturb the stored bit; a decoder that matched only the low address bits would overwrite the flag.

// File: rtl/hypenv_pkg.sv
package hypenv_pkg;
  localparam int FENCE_W     = 8;
  localparam int SET_W       = 4;
  localparam int NUM_SETS    = FENCE_W / SET_W;
  // bit offsets inside one ordering set (successor at 0, predecessor at SET_W)
  localparam int OFS_DEV_IN  = 3;
  localparam int OFS_DEV_OUT = 2;
  localparam int OFS_MEM_RD  = 1;
  localparam int OFS_MEM_WR  = 0;
  localparam int FLAG_BIT    = 0;
endpackage

// File: rtl/hypenv_rst_sync.sv
module hypenv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/hypenv_cfg_reg.sv
module hypenv_cfg_reg #(
  parameter int          XLEN     = 64,
  parameter int          AW       = 12,
  parameter logic [11:0] CFG_ADDR = 12'h60A,
  parameter logic [11:0] HI_ADDR  = 12'h61A
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            we,
  input  logic            re,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rdata,
  output logic            unmapped,
  output logic            flag
);
  import hypenv_pkg::*;

  localparam logic [AW-1:0] CFG_A = AW'(CFG_ADDR);
  localparam logic [AW-1:0] HI_A  = AW'(HI_ADDR);

  logic hit_cfg;
  logic hit_hi;
  logic access;
  logic hi_present;
  logic flag_en;
  logic flag_d;
  logic flag_q;

  assign hit_cfg = (addr == CFG_A);
  assign hit_hi  = (addr == HI_A);
  assign access  = we | re;

  generate
    if (XLEN == 32) begin : g_hi_half
      assign hi_present = 1'b1;
    end else begin : g_no_hi_half
      assign hi_present = 1'b0;
    end
  endgenerate

  // next state
  always_comb begin
    flag_en = we & hit_cfg;
    flag_d  = flag_q;
    if (flag_en) flag_d = wdata[FLAG_BIT];
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  // read path: the high half and all reserved bits read as zero
  always_comb begin
    rdata = '0;
    if (re && hit_cfg) rdata[FLAG_BIT] = flag_q;
  end

  assign unmapped = access & hit_hi & ~hi_present;
  assign flag     = flag_q;

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && hit_cfg) |=> (flag_q == $past(wdata[FLAG_BIT])));
  p_hold_without_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && hit_cfg) |=> $stable(flag_q));
  p_unmapped_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (rdata == '0));
  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[XLEN-1:1] == '0));
endmodule

// File: rtl/hypenv_fence_widen.sv
module hypenv_fence_widen (
  input  logic [hypenv_pkg::FENCE_W-1:0] fence_in,
  input  logic                           widen_en,
  output logic [hypenv_pkg::FENCE_W-1:0] fence_out
);
  import hypenv_pkg::*;

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
    localparam int B = g * SET_W;
    assign fence_out[B+OFS_DEV_IN]  = fence_in[B+OFS_DEV_IN];
    assign fence_out[B+OFS_DEV_OUT] = fence_in[B+OFS_DEV_OUT];
    assign fence_out[B+OFS_MEM_RD]  = fence_in[B+OFS_MEM_RD]
                                    | (widen_en & fence_in[B+OFS_DEV_IN]);
    assign fence_out[B+OFS_MEM_WR]  = fence_in[B+OFS_MEM_WR]
                                    | (widen_en & fence_in[B+OFS_DEV_OUT]);
  end
endmodule

// File: rtl/hyp_envcfg_fence.sv
module hyp_envcfg_fence #(
  parameter int          XLEN     = 64,
  parameter int          AW       = 12,
  parameter logic [11:0] CFG_ADDR = 12'h60A,
  parameter logic [11:0] HI_ADDR  = 12'h61A
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   csr_addr,
  input  logic            csr_we,
  input  logic            csr_re,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_unmapped,
  input  logic            virt_mode,
  input  logic [7:0]      fence_in,
  output logic [7:0]      fence_out
);
  logic rst_sync_n;
  logic flag;
  logic widen_en;

  hypenv_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hypenv_cfg_reg #(
    .XLEN     (XLEN),
    .AW       (AW),
    .CFG_ADDR (CFG_ADDR),
    .HI_ADDR  (HI_ADDR)
  ) u_reg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .addr     (csr_addr),
    .we       (csr_we),
    .re       (csr_re),
    .wdata    (csr_wdata),
    .rdata    (csr_rdata),
    .unmapped (csr_unmapped),
    .flag     (flag)
  );

  assign widen_en = flag & virt_mode;

  hypenv_fence_widen u_widen (
    .fence_in  (fence_in),
    .widen_en  (widen_en),
    .fence_out (fence_out)
  );

  p_passthrough_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(flag && virt_mode) |-> (fence_out == fence_in));
  p_only_adds_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((fence_out & fence_in) == fence_in));
  p_unmapped_keeps_flag_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    csr_unmapped |=> $stable(flag));
  p_quiet_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(csr_we || csr_re) |-> !csr_unmapped);
endmodule

// File: tb/hyp_envcfg_fence_tb_top.sv
module hyp_envcfg_fence_tb_top;
  localparam logic [11:0] A_CFG = 12'h60A;
  localparam logic [11:0] A_HI  = 12'h61A;
  localparam logic [11:0] A_OTH = 12'h123;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] csr_addr;
  logic        csr_we, csr_re, virt_mode;
  logic [63:0] csr_wdata;
  logic [7:0]  fence_in;
  logic [63:0] rd64;
  logic [31:0] rd32;
  logic        um64, um32;
  logic [7:0]  fo64, fo32;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  hyp_envcfg_fence #(.XLEN(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_re(csr_re), .csr_wdata(csr_wdata), .csr_rdata(rd64),
    .csr_unmapped(um64), .virt_mode(virt_mode), .fence_in(fence_in),
    .fence_out(fo64));

  hyp_envcfg_fence #(.XLEN(32)) dut32_i (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_re(csr_re), .csr_wdata(csr_wdata[31:0]), .csr_rdata(rd32),
    .csr_unmapped(um32), .virt_mode(virt_mode), .fence_in(fence_in),
    .fence_out(fo32));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model(logic [7:0] f, logic en);
    logic [7:0] o = f;
    if (en) begin
      o[5] = f[5] | f[7];
      o[4] = f[4] | f[6];
      o[1] = f[1] | f[3];
      o[0] = f[0] | f[2];
    end
    return o;
  endfunction

  task automatic csr_write(logic [11:0] a, logic [63:0] d);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_read(logic [11:0] a, output logic [63:0] d64,
                          output logic [31:0] d32, output logic u64,
                          output logic u32);
    @(negedge clk);
    csr_addr = a; csr_re = 1'b1;
    #1;
    d64 = rd64; d32 = rd32; u64 = um64; u32 = um32;
    @(negedge clk);
    csr_re = 1'b0;
  endtask

  task automatic t_reset;
    logic [63:0] d; logic [31:0] e; logic u, v;
    csr_read(A_CFG, d, e, u, v);
    chk("R1 cfg read 64", d, 64'd0);
    chk("R1 cfg read 32", {32'd0, e}, 64'd0);
    @(negedge clk); virt_mode = 1'b1; fence_in = 8'hCC; #1;
    chk("R1 no widening after reset", {56'd0, fo64}, 64'hCC);
  endtask

  task automatic t_write_read;
    logic [63:0] d; logic [31:0] e; logic u, v;
    csr_write(A_CFG, '1);
    csr_read(A_CFG, d, e, u, v);
    chk("R2 flag set 64", d[0], 1);
    chk("R2 flag set 32", e[0], 1);
    chk("R3 reserved zero 64", d, 64'd1);
    chk("R3 reserved zero 32", {32'd0, e}, 64'd1);
    chk("R11 cfg read no unmapped", {u, v}, 0);
    csr_write(A_CFG, 64'hFFFF_FFFF_FFFF_FFFE);
    csr_read(A_CFG, d, e, u, v);
    chk("R2 flag cleared", d, 64'd0);
    chk("R3 reserved writes ignored", {32'd0, e}, 64'd0);
  endtask

  task automatic t_passthrough;
    csr_write(A_CFG, 64'd0);
    for (int m = 0; m < 2; m++)
      for (int f = 0; f < 256; f++) begin
        @(negedge clk); virt_mode = m[0]; fence_in = f[7:0]; #1;
        chk("R4 flag off passthrough", {56'd0, fo64}, {56'd0, f[7:0]});
      end
    csr_write(A_CFG, 64'd1);
    for (int f = 0; f < 256; f++) begin
      @(negedge clk); virt_mode = 1'b0; fence_in = f[7:0]; #1;
      chk("R4 mode off passthrough", {56'd0, fo32}, {56'd0, f[7:0]});
    end
  endtask

  task automatic t_widen;
    csr_write(A_CFG, 64'd1);
    @(negedge clk); virt_mode = 1'b1;
    fence_in = 8'h80; #1; chk("R5 PI->PR", {56'd0, fo64}, 64'hA0);
    @(negedge clk); fence_in = 8'h40; #1; chk("R5 PO->PW", {56'd0, fo64}, 64'h50);
    @(negedge clk); fence_in = 8'h08; #1; chk("R6 SI->SR", {56'd0, fo64}, 64'h0A);
    @(negedge clk); fence_in = 8'h04; #1; chk("R6 SO->SW", {56'd0, fo32}, 64'h05);
    @(negedge clk); fence_in = 8'h33; #1; chk("R7 memory bits kept", {56'd0, fo64}, 64'h33);
    for (int f = 0; f < 256; f++) begin
      @(negedge clk); fence_in = f[7:0]; #1;
      chk("R7 full sweep widen", {56'd0, fo64}, {56'd0, model(f[7:0], 1'b1)});
    end
  endtask

  task automatic t_same_cycle;
    csr_write(A_CFG, 64'd0);
    @(negedge clk);
    virt_mode = 1'b1; fence_in = 8'h80;
    csr_addr = A_CFG; csr_wdata = 64'd1; csr_we = 1'b1;
    #1;
    chk("R10 old flag in write cycle", {56'd0, fo64}, 64'h80);
    @(negedge clk); csr_we = 1'b0; #1;
    chk("R10 new flag after edge", {56'd0, fo64}, 64'hA0);
  endtask

  task automatic t_hi64;
    logic [63:0] d; logic [31:0] e; logic u, v;
    csr_write(A_CFG, 64'd1);
    csr_read(A_HI, d, e, u, v);
    chk("R9 unmapped on read", u, 1);
    chk("R9 read data zero", d, 0);
    @(negedge clk); csr_addr = A_HI; csr_wdata = 64'd0; csr_we = 1'b1; #1;
    chk("R9 unmapped on write", um64, 1);
    @(negedge clk); csr_we = 1'b0; #1;
    chk("R11 idle no unmapped", um64, 0);
    csr_read(A_CFG, d, e, u, v);
    chk("R9 flag unchanged", d, 64'd1);
    csr_read(A_OTH, d, e, u, v);
    chk("R11 other address silent", {u, v}, 0);
    chk("R11 other address reads zero", d, 0);
  endtask

  task automatic t_hi32;
    logic [63:0] d; logic [31:0] e; logic u, v;
    csr_write(A_HI, '1);
    csr_read(A_HI, d, e, u, v);
    chk("R8 hi reads zero", {32'd0, e}, 0);
    chk("R8 no unmapped at 32", v, 0);
    csr_read(A_CFG, d, e, u, v);
    chk("R8 cfg untouched by hi write", {32'd0, e}, 64'd1);
  endtask

  initial begin
    rst_n = 1'b0; csr_addr = '0; csr_we = 1'b0; csr_re = 1'b0;
    csr_wdata = '0; virt_mode = 1'b0; fence_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write_read();
    t_passthrough();
    t_widen();
    t_same_cycle();
    t_hi64();
    t_hi32();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule